// File: doc/BRIEF.md
# Three-Phase Motor PWM Generator

This block drives the three phase legs (U, V, W) of a motor inverter from a single shared PWM counter. The counter advances on a divided clock and runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each phase compares the counter against its own compare word. A phase may also be forced to full duty for one PWM period. A resolution bit selects whether the compare word's top `WIDE_W` bits or only its top `NARROW_W` bits form the compare value. The counter period follows from the largest value the selected field can hold.

Software-facing writes land in preload registers. Nothing reaches the outputs until the next update event, which is a counter wrap in edge-aligned mode or the bottom reversal in center-aligned mode. At that moment the compare words and the control word move into the active set, and the outputs are then computed from that set. An `upd_evt` strobe marks each transfer. The counter direction is held by a two-state machine:

- `CNT_UP` is the rising state. Transition *climb* stays in `CNT_UP` and adds one. Transition *wrap* is taken in edge-aligned mode at the maximum: it stays in `CNT_UP`, returns to zero and raises the update. Transition *peak* is taken in center-aligned mode at the maximum: it moves to `CNT_DOWN` at maximum minus one.
- `CNT_DOWN` is the falling state. Transition *descend* stays in `CNT_DOWN` and subtracts one. Transition *bottom* is taken from a count of one: it moves to `CNT_UP` at zero and raises the update.

Top module: `tri_phase_pwm`

## Requirements
- R1: After reset the control word is zero. This gives wide resolution, edge-aligned counting, divide-by-1 and no overrides. All compare words are zero and all outputs and `upd_evt` are low. The first update follows 2^WIDE_W enabled cycles after reset.
- R2: Control bits [4:2] hold a prescale code N. The counter moves once every N+1 enabled clock cycles, so the divide ratio ranges from 1 to 8.
- R3: With control bit 0 clear (edge-aligned), the counter runs 0 to MAX and wraps to 0. The period is MAX+1 counter steps, and the wrap is the update event.
- R4: With control bit 0 set (center-aligned), the counter rises from 0 to MAX and falls back toward 0. The period is 2*MAX counter steps, and the return to 0 is the update event.
- R5: A phase output is high exactly while the counter is below that phase's active compare value. A compare value of 0 keeps the output low.
- R6: With control bit 1 clear, the compare value is bits [REG_W-1:REG_W-WIDE_W] of the compare word and MAX is 2^WIDE_W-1. With control bit 1 set, the compare value is bits [REG_W-1:REG_W-NARROW_W] and MAX is 2^NARROW_W-1. In either case the remaining low bits have no effect.
- R7: The write port uses address 0 for the U compare word, 1 for V, 2 for W and 3 for the control word. A write changes nothing at the outputs until the next update event.
- R8: Control bits 5, 6 and 7 are the override flags for U, V and W. An override flag set in the preload holds its phase high for the whole PWM period that follows the next update event.
- R9: Each preload override flag clears itself when it is transferred. Unless it is rewritten, the period after an override period returns to compare-based duty.
- R10: In narrow mode the override flag acts as the ninth, most significant compare bit. This yields a compare value above MAX, and therefore full duty.
- R11: `upd_evt` is a one-cycle pulse in the first clock cycle that uses the newly transferred values. No other pulse occurs within the period.
- R12: While `clk_en` is low, the counter, the prescaler and the outputs hold their values and no update occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 U, 1 V, 2 W, 3 control) |
| wr_data | input | REG_W | Write data |
| pwm_u | output | 1 | Phase U output |
| pwm_v | output | 1 | Phase V output |
| pwm_w | output | 1 | Phase W output |
| upd_evt | output | 1 | Update event pulse |

## Verification
The bench sweeps every narrow compare value in both counter modes, with junk in the ignored low bits. Decoding the wrong slice of the word would give counts matching the wide interpretation. It also drives the wide-mode extremes 0, 1, MAX-1 and MAX. A triangle that visited 0 or MAX twice would give 2c rather than 2c-1 high cycles, and a sawtooth with an off-by-one period would move `upd_evt` by a step. Each case looks at three periods: the one in which the writes land, the override period, and the period after it. This catches a preload that leaks early and an override flag that never clears. A separate pass sweeps all eight prescale codes, and another stalls `clk_en` mid-run.

// File: rtl/tpp_pkg.sv
`timescale 1ns/1ps
package tpp_pkg;

    localparam int NPH     = 3;
    localparam int PRESC_W = 3;
    localparam int CTRL_W  = 8;

    localparam logic [1:0] ADDR_U    = 2'd0;
    localparam logic [1:0] ADDR_V    = 2'd1;
    localparam logic [1:0] ADDR_W    = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_t;

    // Control word, MSB first: ovr[7:5] (W,V,U), presc[4:2], narrow[1], center[0]
    typedef struct packed {
        logic [NPH-1:0]     ovr;
        logic [PRESC_W-1:0] presc;
        logic               narrow;
        logic               center;
    } tpp_ctrl_t;

endpackage

// File: rtl/tpp_prescaler.sv
`timescale 1ns/1ps
module tpp_prescaler
    import tpp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en,
    input  logic [PRESC_W-1:0] code,
    output logic               tick
);

    logic [PRESC_W-1:0] pre_q;
    logic               at_last;

    // ">=" keeps the divider sane if the code shrinks mid-window
    assign at_last = (pre_q >= code);
    assign tick    = clk_en && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clk_en) begin
            if (at_last) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRESC_W'(1);
            end
        end
    end

endmodule

// File: rtl/tpp_counter.sv
`timescale 1ns/1ps
module tpp_counter
    import tpp_pkg::*;
#(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          center,
    input  logic [CW-1:0] max_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_dir_t      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          at_top;
    logic          at_bottom;

    assign at_top    = (cnt_q >= max_val);
    assign at_bottom = (cnt_q <= ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                CNT_UP: begin
                    if (at_top) begin
                        if (center) begin          // peak
                            state_d = CNT_DOWN;
                            cnt_d   = max_val - ONE;
                        end else begin             // wrap
                            cnt_d   = '0;
                        end
                    end else begin                 // climb
                        cnt_d = cnt_q + ONE;
                    end
                end
                CNT_DOWN: begin
                    if (at_bottom) begin           // bottom
                        state_d = CNT_UP;
                        cnt_d   = '0;
                    end else begin                 // descend
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = CNT_UP;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt  = cnt_q;
        wrap = 1'b0;
        if (tick) begin
            unique case (state_q)
                CNT_UP:   wrap = at_top && !center;
                CNT_DOWN: wrap = at_bottom;
                default:  wrap = 1'b0;
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= max_val);  // R6

    AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_DOWN && $past(state_q) == CNT_UP) |-> ($past(cnt_q) == $past(max_val)));  // R4

endmodule

// File: rtl/tpp_regs.sv
`timescale 1ns/1ps
module tpp_regs
    import tpp_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      upd,
    output tpp_ctrl_t                 ctrl_act,
    output logic [NPH-1:0][REG_W-1:0] cmp_act
);

    tpp_ctrl_t                 ctrl_pre_q, ctrl_act_q;
    logic [NPH-1:0][REG_W-1:0] cmp_pre_q, cmp_act_q;
    logic                      wr_ctrl;
    logic                      unused_wr_hi;

    assign wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
    assign unused_wr_hi = ^wr_data;

    // Compare preload and active words, one pair per phase
    for (genvar p = 0; p < NPH; p++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_pre_q[p] <= '0;
                cmp_act_q[p] <= '0;
            end else begin
                if (upd) begin
                    cmp_act_q[p] <= cmp_pre_q[p];
                end
                if (wr_en && (wr_addr == 2'(p))) begin
                    cmp_pre_q[p] <= wr_data;
                end
            end
        end
    end

    // Control word: overrides self-clear on transfer, a same-cycle write wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_pre_q <= '0;
            ctrl_act_q <= '0;
        end else begin
            if (upd) begin
                ctrl_act_q     <= ctrl_pre_q;
                ctrl_pre_q.ovr <= '0;
            end
            if (wr_ctrl) begin
                ctrl_pre_q <= tpp_ctrl_t'(wr_data[CTRL_W-1:0]);
            end
        end
    end

    assign ctrl_act = ctrl_act_q;
    assign cmp_act  = cmp_act_q;

    AST_OVR_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_ctrl) |=> (ctrl_pre_q.ovr == '0));  // R9

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(ctrl_act_q) && $stable(cmp_act_q)));  // R7

endmodule

// File: rtl/tpp_channel.sv
`timescale 1ns/1ps
module tpp_channel #(
    parameter int REG_W    = 16,
    parameter int WIDE_W   = 13,
    parameter int NARROW_W = 8
) (
    input  logic [REG_W-1:0]  cmp_raw,
    input  logic              narrow,
    input  logic              ovr,
    input  logic [WIDE_W-1:0] cnt,
    output logic              pwm
);

    localparam int EW = WIDE_W + 1;

    logic [WIDE_W-1:0]   f_wide;
    logic [NARROW_W-1:0] f_narrow;
    logic [EW-1:0]       eff_wide, eff_narrow, eff;
    logic                unused_low;

    assign f_wide     = cmp_raw[REG_W-1 -: WIDE_W];
    assign f_narrow   = cmp_raw[REG_W-1 -: NARROW_W];
    assign unused_low = ^cmp_raw;

    // The override sits above the field's MSB, so it lifts the value past MAX
    assign eff_wide   = {ovr, f_wide};
    assign eff_narrow = EW'({ovr, f_narrow});
    assign eff        = narrow ? eff_narrow : eff_wide;

    assign pwm = ({1'b0, cnt} < eff);

endmodule

// File: rtl/tri_phase_pwm.sv
`timescale 1ns/1ps
module tri_phase_pwm
    import tpp_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int WIDE_W   = 13,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             pwm_u,
    output logic             pwm_v,
    output logic             pwm_w,
    output logic             upd_evt
);

    localparam logic [WIDE_W-1:0] MAX_WIDE   = '1;
    localparam logic [WIDE_W-1:0] MAX_NARROW = WIDE_W'((1 << NARROW_W) - 1);

    tpp_ctrl_t                 ctrl_act;
    logic [NPH-1:0][REG_W-1:0] cmp_act;
    logic [WIDE_W-1:0]         max_val;
    logic [WIDE_W-1:0]         cnt;
    logic                      tick;
    logic                      wrap;
    logic                      upd_q;
    logic [NPH-1:0]            pwm_vec;

    assign max_val = ctrl_act.narrow ? MAX_NARROW : MAX_WIDE;

    tpp_prescaler u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .code   (ctrl_act.presc),
        .tick   (tick)
    );

    tpp_counter #(.CW(WIDE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .center  (ctrl_act.center),
        .max_val (max_val),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    tpp_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .upd      (wrap),
        .ctrl_act (ctrl_act),
        .cmp_act  (cmp_act)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        tpp_channel #(
            .REG_W    (REG_W),
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W)
        ) u_ch (
            .cmp_raw (cmp_act[p]),
            .narrow  (ctrl_act.narrow),
            .ovr     (ctrl_act.ovr[p]),
            .cnt     (cnt),
            .pwm     (pwm_vec[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= wrap;
        end
    end

    assign pwm_u   = pwm_vec[0];
    assign pwm_v   = pwm_vec[1];
    assign pwm_w   = pwm_vec[2];
    assign upd_evt = upd_q;

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cnt));  // R12

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> !upd_evt);  // R11

endmodule

// File: tb/sim_tri_phase_pwm.sv
`timescale 1ns/1ps
module sim_tri_phase_pwm;

    localparam int RW = 8;
    localparam int WW = 6;
    localparam int NW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic          pwm_u, pwm_v, pwm_w, upd_evt;

    int n_checks = 0;
    int n_fail   = 0;

    logic [RW-1:0] cur_d [3];
    logic [2:0]    cur_ovr;
    bit            cur_center, cur_narrow;
    int            cur_code;

    int            wq_n = 0;
    logic [1:0]    wq_a [4];
    logic [RW-1:0] wq_d [4];

    always #5 clk = ~clk;

    tri_phase_pwm #(.REG_W(RW), .WIDE_W(WW), .NARROW_W(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w), .upd_evt(upd_evt)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int max_of(bit nar);
        return nar ? (1 << NW) - 1 : (1 << WW) - 1;
    endfunction

    function automatic int field_of(logic [RW-1:0] d, bit nar);
        return nar ? int'(d[RW-1 -: NW]) : int'(d[RW-1 -: WW]);
    endfunction

    function automatic int ticks_per(bit cen, bit nar);
        return cen ? 2 * max_of(nar) : max_of(nar) + 1;
    endfunction

    function automatic int exp_ticks(int c, bit o, bit cen, bit nar);
        if (o) return ticks_per(cen, nar);
        if (cen) return (c == 0) ? 0 : 2 * c - 1;
        return c;
    endfunction

    // Starts on the cycle that shows upd_evt; ends on the next such cycle
    task automatic measure_period(string req);
        int n;
        int hi [3];
        int extra;
        n = ticks_per(cur_center, cur_narrow) * (cur_code + 1);
        hi = '{0, 0, 0};
        extra = 0;
        for (int i = 0; i < n; i++) begin
            hi[0] += int'(pwm_u);
            hi[1] += int'(pwm_v);
            hi[2] += int'(pwm_w);
            if (i > 0 && upd_evt) extra++;
            if (i < wq_n) begin
                wr_en = 1'b1; wr_addr = wq_a[i]; wr_data = wq_d[i];
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        wq_n = 0;
        for (int p = 0; p < 3; p++) begin
            int e;
            e = exp_ticks(field_of(cur_d[p], cur_narrow), cur_ovr[p], cur_center, cur_narrow)
                * (cur_code + 1);
            chk(hi[p] == e, req, $sformatf("phase %0d high cycles", p), hi[p], e);
        end
        chk(upd_evt == 1'b1 && extra == 0, cur_center ? "R4 R11" : "R3 R11",
            "update strobe only at period end", int'(upd_evt) + 2 * extra, 1);
    endtask

    // Three periods: writes land (old values), override period, following period
    task automatic do_case(logic [RW-1:0] du, logic [RW-1:0] dv, logic [RW-1:0] dw,
                           logic [2:0] o, bit cen, bit nar, int code, string req);
        logic [2:0] pc;
        pc = 3'(code);
        wq_a[0] = 2'd0; wq_d[0] = du;
        wq_a[1] = 2'd1; wq_d[1] = dv;
        wq_a[2] = 2'd2; wq_d[2] = dw;
        wq_a[3] = 2'd3; wq_d[3] = {o, pc, nar, cen};
        wq_n = 4;
        measure_period("R7");
        cur_d[0] = du; cur_d[1] = dv; cur_d[2] = dw;
        cur_ovr = o; cur_center = cen; cur_narrow = nar; cur_code = code;
        measure_period(req);
        cur_ovr = 3'b000;
        measure_period("R9");
    endtask

    initial begin
        int k;
        int wide_vals [6];
        int mism;
        logic pu, pv, pw;
        wide_vals = '{0, 1, 2, 31, 62, 63};
        cur_d = '{default: '0};
        cur_ovr = 3'b000; cur_center = 1'b0; cur_narrow = 1'b0; cur_code = 0;

        repeat (3) @(negedge clk);
        chk({pwm_u, pwm_v, pwm_w, upd_evt} == 4'b0000, "R1", "outputs during reset",
            int'({pwm_u, pwm_v, pwm_w, upd_evt}), 0);
        rst_n = 1'b1;
        clk_en = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1)
                chk({pwm_u, pwm_v, pwm_w} == 3'b000, "R1", "outputs after reset",
                    int'({pwm_u, pwm_v, pwm_w}), 0);
        end while (!upd_evt && k < 1000);
        chk(k == 64, "R1", "cycles to first update", k, 64);

        // Narrow field, exhaustive compare sweep, junk in ignored bits (R6, R10)
        for (int cen = 0; cen < 2; cen++) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] cu, cv, o;
                cu = 3'(c);
                cv = 3'(7 - c);
                o  = (c == 7) ? 3'b111 : ((c == 3) ? 3'b010 : 3'b000);
                do_case({cu, 5'b10110}, {cv, 5'b01001}, {cu ^ 3'b101, 5'b11111},
                        o, cen[0], 1'b1, cen, "R5 R6 R8 R10");
            end
        end

        // Wide field extremes in both counter modes
        for (int cen = 0; cen < 2; cen++) begin
            for (int i = 0; i < 6; i++) begin
                logic [5:0] c;
                c = 6'(wide_vals[i]);
                do_case({c, 2'b11}, {6'd63 - c, 2'b01}, {c ^ 6'h2A, 2'b10},
                        (i == 2) ? 3'b101 : 3'b000, cen[0], 1'b0, 0, "R5 R6 R8");
            end
        end

        // Prescale sweep
        for (int code = 0; code < 8; code++) begin
            do_case({3'd5, 5'd0}, {3'd1, 5'd0}, {3'd7, 5'd3},
                    (code == 4) ? 3'b001 : 3'b000, 1'b0, 1'b1, code, "R2 R5");
        end
        do_case({6'd40, 2'b00}, {6'd3, 2'b00}, {6'd63, 2'b00}, 3'b100, 1'b1, 1'b0, 7, "R2 R4 R8");

        // Enable stall
        clk_en = 1'b0;
        pu = pwm_u; pv = pwm_v; pw = pwm_w;
        mism = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (pwm_u != pu || pwm_v != pv || pwm_w != pw || upd_evt) mism++;
        end
        chk(mism == 0, "R12", "frozen cycles with change", mism, 0);
        clk_en = 1'b1;
        measure_period("R12 R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule